// File: doc/BRIEF.md
# Multiplexed Three-Digit Display Scanner

This block shares a single four-bit BCD bus among three stored decimal digits: units, tens and hundreds. It places the digits on the bus one after another. For each digit it pulls one active-low select line, so the display position being driven is the one that matches the data on the bus. The bus itself is active high. Every select line and the bus are combinational functions of the scan position and the reset input, so a select and its digit always change in the same cycle.

The scan position advances on a step event. A mode input picks the source of that event. The first source is an internal divider of the system clock, whose terminal count can be changed while the block runs. The second is the rising edge of an asynchronous external scan clock, which passes through a two-stage synchronizer first. A synchronous master reset parks the position on the units digit, holds all select lines inactive, forces the bus to zero and stops stepping. This blanks the display while the counters behind it are being cleared. The digit inputs are static levels from the counter latches, so there is no handshake: the bus simply follows the selected input.

Top module: `digit_scan_mux`

## Requirements
- R1: Outside master reset, exactly one bit of `sel_n` is low. Bit 0 selects units, bit 1 selects tens and bit 2 selects hundreds.
- R2: Outside master reset, `bcd_out` equals the digit whose select is low. Digit i is taken from `digits_in[4*i+3:4*i]`, so units sit in [3:0], tens in [7:4] and hundreds in [11:8].
- R3: In any cycle where `mreset` is 1, `sel_n` is all ones and `bcd_out` is 0. This takes effect combinationally, in the same cycle, and no stepping happens while reset is held.
- R4: After `mreset` falls, the first select driven low is the units select. In divider mode it stays low for a full `div_limit`+1 cycles.
- R5: Steps go units to tens, tens to hundreds, and hundreds back to units.
- R6: In divider mode (`use_ext`=0), the position advances once every `div_limit`+1 clock cycles. A `div_limit` of 0 advances it every cycle.
- R7: In external mode (`use_ext`=1), the position advances exactly once for each rising edge of `ext_scan`, and the change appears on the third clock edge after the rise. Falling edges and `div_limit` have no effect.
- R8: In divider mode, activity on `ext_scan` has no effect on the position.
- R9: If `div_limit` is lowered below the current divider count, the next clock edge performs a step, and stepping then continues every `div_limit`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Synchronous master reset, active high. Hold it for at least 3 cycles so the synchronizer settles |
| use_ext | input | 1 | 0: internal divider steps the scan; 1: external scan clock steps it |
| ext_scan | input | 1 | Asynchronous external scan clock; its rising edges step the scan |
| div_limit | input | DIV_W | Divider terminal count; one step per div_limit+1 cycles |
| digits_in | input | DIGITS*DIGIT_W | Latched digits, units in the lowest nibble |
| bcd_out | output | DIGIT_W | Active-high BCD of the selected digit |
| sel_n | output | DIGITS | Active-low digit selects, bit 0 = units |

## Verification
The hardest case to reach is a divider terminal count lowered below a count already in progress. The stimulus sets a large limit, lets the count climb for ten cycles, then cuts the limit to 2 and expects a step on the very next edge. A second hard case is master reset arriving in the middle of a scan. The bench runs the scan to the hundreds digit, raises reset between edges, and checks both the immediate blanking and a restart on units. In external mode the divider limit is set to 0, so any leak from the divider would show up as a step on every cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    SRC_DIVIDER  = 1'b0,
    SRC_EXTERNAL = 1'b1
  } scan_src_e;
endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen
  import scan_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mreset,
  input  scan_src_e        src,
  input  logic             ext_scan,
  input  logic [DIV_W-1:0] div_limit,
  output logic             step
);
  // Synchronizer stages plus one history bit for the edge detector.
  localparam int HIST = SYNC_STAGES + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [HIST-1:0]  sync_q;
  logic             term;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[HIST-2:0], ext_scan};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  // ">=" so that lowering the limit mid-count still terminates promptly.
  assign term     = (cnt_q >= div_limit);

  always_ff @(posedge clk) begin
    if (mreset || src != SRC_DIVIDER) begin
      cnt_q <= '0;
    end else if (term) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    step = 1'b0;
    if (!mreset) begin
      step = (src == SRC_DIVIDER) ? term : ext_rise;
    end
  end
endmodule

// File: rtl/scan_ring.sv
module scan_ring #(
  parameter int N = 3
) (
  input  logic                 clk,
  input  logic                 mreset,
  input  logic                 step,
  output logic [N-1:0]         ring,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_ff @(posedge clk) begin
    if (mreset) begin
      ring <= N'(1);
    end else if (step) begin
      ring <= {ring[N-2:0], ring[N-1]};
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ring[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
  parameter int N  = 3,
  parameter int DW = 4
) (
  input  logic                 blank,
  input  logic [N-1:0]         ring,
  input  logic [$clog2(N)-1:0] idx,
  input  logic [N*DW-1:0]      digits,
  output logic [DW-1:0]        bcd,
  output logic [N-1:0]         sel_n
);
  logic [DW-1:0] dig_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign dig_arr[g] = digits[g*DW +: DW];
  end

  assign sel_n = blank ? '1 : ~ring;
  assign bcd   = blank ? '0 : dig_arr[idx];
endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux
  import scan_pkg::*;
#(
  parameter int DIGITS  = 3,
  parameter int DIGIT_W = 4,
  parameter int DIV_W   = 16
) (
  input  logic                      clk,
  input  logic                      mreset,
  input  logic                      use_ext,
  input  logic                      ext_scan,
  input  logic [DIV_W-1:0]          div_limit,
  input  logic [DIGITS*DIGIT_W-1:0] digits_in,
  output logic [DIGIT_W-1:0]        bcd_out,
  output logic [DIGITS-1:0]         sel_n
);
  localparam int IDX_W = $clog2(DIGITS);

  logic              step;
  logic [DIGITS-1:0] ring;
  logic [IDX_W-1:0]  idx;

  scan_tick_gen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_tick (
    .clk       (clk),
    .mreset    (mreset),
    .src       (scan_src_e'(use_ext)),
    .ext_scan  (ext_scan),
    .div_limit (div_limit),
    .step      (step)
  );

  scan_ring #(.N(DIGITS)) u_ring (
    .clk    (clk),
    .mreset (mreset),
    .step   (step),
    .ring   (ring),
    .idx    (idx)
  );

  digit_mux #(.N(DIGITS), .DW(DIGIT_W)) u_mux (
    .blank  (mreset),
    .ring   (ring),
    .idx    (idx),
    .digits (digits_in),
    .bcd    (bcd_out),
    .sel_n  (sel_n)
  );
endmodule

// File: rtl/digit_scan_mux_chk.sv
module digit_scan_mux_chk #(
  parameter int N  = 3,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          mreset,
  input logic [N-1:0]  sel_n,
  input logic [DW-1:0] bcd_out,
  input logic [N*DW-1:0] digits_in
);
  logic [N-1:0]  act;
  logic [DW-1:0] chosen;

  assign act = ~sel_n;

  always_comb begin
    chosen = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) chosen = digits_in[i*DW +: DW];
    end
  end

  assert_one_select_R1: assert property (@(posedge clk) disable iff (mreset)
    $countones(act) == 1);

  assert_bus_matches_R2: assert property (@(posedge clk) disable iff (mreset)
    bcd_out == chosen);

  // R3: blanking while reset is high (not disabled by reset)
  assert_reset_blank_R3: assert property (@(posedge clk)
    mreset |-> (sel_n == '1 && bcd_out == '0));

  assert_first_units_R4: assert property (@(posedge clk) disable iff (mreset)
    $fell(mreset) |-> act == N'(1));

  assert_scan_order_R5: assert property (@(posedge clk) disable iff (mreset)
    (!$past(mreset) && act != $past(act)) |->
      act == {$past(act[N-2:0]), $past(act[N-1])});
endmodule

bind digit_scan_mux digit_scan_mux_chk #(.N(DIGITS), .DW(DIGIT_W)) u_chk (
  .clk       (clk),
  .mreset    (mreset),
  .sel_n     (sel_n),
  .bcd_out   (bcd_out),
  .digits_in (digits_in)
);

// File: tb/digit_scan_mux_test.sv
module digit_scan_mux_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int DW = 4;
  localparam int DIV_W = 16;

  logic              clk = 1'b0;
  logic              mreset = 1'b1;
  logic              use_ext = 1'b0;
  logic              ext_scan = 1'b0;
  logic [DIV_W-1:0]  div_limit = '0;
  logic [N*DW-1:0]   digits_in = {4'd9, 4'd5, 4'd2};
  logic [DW-1:0]     bcd_out;
  logic [N-1:0]      sel_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_scan_mux #(.DIGITS(N), .DIGIT_W(DW), .DIV_W(DIV_W)) uut (
    .clk       (clk),
    .mreset    (mreset),
    .use_ext   (use_ext),
    .ext_scan  (ext_scan),
    .div_limit (div_limit),
    .digits_in (digits_in),
    .bcd_out   (bcd_out),
    .sel_n     (sel_n)
  );

  task automatic expect_digit(input int d, input string tag);
    logic [N-1:0]  exp_sel;
    logic [DW-1:0] exp_bcd;
    exp_sel = ~(N'(1) << d);
    exp_bcd = digits_in[d*DW +: DW];
    checks++;
    if (sel_n !== exp_sel || bcd_out !== exp_bcd) begin
      fails++;
      $display("FAIL %s: sel_n=%b bcd=%0d expected sel_n=%b bcd=%0d",
               tag, sel_n, bcd_out, exp_sel, exp_bcd);
    end
  endtask

  task automatic expect_blank(input string tag);
    checks++;
    if (sel_n !== '1 || bcd_out !== '0) begin
      fails++;
      $display("FAIL %s: sel_n=%b bcd=%0d expected sel_n=111 bcd=0",
               tag, sel_n, bcd_out);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    mreset = 1'b1;
    repeat (cycles) @(negedge clk);
    expect_blank("R3 blank during reset");
    mreset = 1'b0;
  endtask

  // R4 R5 R6: divider limit 3, four cycles per digit
  task automatic t_internal_scan();
    use_ext = 1'b0;
    div_limit = 16'd3;
    digits_in = {4'd9, 4'd5, 4'd2};
    do_reset(4);
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      if (cyc == 3) expect_digit(0, "R4 units held full period");
      else expect_digit((cyc / 4) % 3, "R5 R6 divider scan");
    end
  endtask

  // R6: limit 0 steps every cycle; R2 with other digits
  task automatic t_div_zero();
    div_limit = 16'd0;
    digits_in = {4'd7, 4'd0, 4'd8};
    do_reset(3);
    for (int cyc = 1; cyc <= 6; cyc++) begin
      @(negedge clk);
      expect_digit(cyc % 3, "R6 R2 limit zero");
    end
  endtask

  // R7: external edges only, divider ignored
  task automatic t_ext_scan();
    use_ext = 1'b1;
    div_limit = 16'd0;
    ext_scan = 1'b0;
    digits_in = {4'd3, 4'd6, 4'd1};
    do_reset(4);
    repeat (6) @(negedge clk);
    expect_digit(0, "R7 no step without edge");
    ext_scan = 1'b1;
    repeat (2) @(negedge clk);
    expect_digit(0, "R7 not before third edge");
    @(negedge clk);
    expect_digit(1, "R7 rise steps once");
    repeat (3) @(negedge clk);
    expect_digit(1, "R7 single step per rise");
    ext_scan = 1'b0;
    repeat (4) @(negedge clk);
    expect_digit(1, "R7 falling edge ignored");
    ext_scan = 1'b1;
    repeat (4) @(negedge clk);
    expect_digit(2, "R7 second rise");
    ext_scan = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // R8: external toggles ignored in divider mode
  task automatic t_ext_ignored();
    use_ext = 1'b0;
    div_limit = 16'd1000;
    do_reset(4);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      ext_scan = ~ext_scan;
      repeat (2) @(negedge clk);
    end
    ext_scan = 1'b0;
    expect_digit(0, "R8 ext ignored in divider mode");
  endtask

  // R3 R4: reset mid-scan
  task automatic t_reset_mid();
    use_ext = 1'b0;
    div_limit = 16'd1;
    do_reset(3);
    repeat (4) @(negedge clk);
    expect_digit(2, "R5 reached hundreds");
    mreset = 1'b1;
    #1;
    expect_blank("R3 immediate blank");
    repeat (3) @(negedge clk);
    expect_blank("R3 held blank no stepping");
    mreset = 1'b0;
    @(negedge clk);
    expect_digit(0, "R4 restart on units");
    @(negedge clk);
    expect_digit(1, "R4 R6 first step after period");
  endtask

  // R9: lowering limit below current count
  task automatic t_shrink();
    use_ext = 1'b0;
    div_limit = 16'd100;
    do_reset(3);
    repeat (10) @(negedge clk);
    expect_digit(0, "R9 before shrink");
    div_limit = 16'd2;
    @(negedge clk);
    expect_digit(1, "R9 step on next edge");
    repeat (2) @(negedge clk);
    expect_digit(1, "R9 hold after shrink");
    @(negedge clk);
    expect_digit(2, "R9 new period");
  endtask

  initial begin
    t_internal_scan();
    t_div_zero();
    t_ext_scan();
    t_ext_ignored();
    t_reset_mid();
    t_shrink();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule